// File: doc/BRIEF.md
# Four-Pin I/O Bank with Clock and Line-Control Alternates

This block owns four bidirectional pads and decides, cycle by cycle, which pads drive, what they drive, and what level each pad reports back. A small register set, written over a one-cycle strobe with a two-bit target select, holds per-pin direction and output values, two alternate-function enables and a divide ratio. Pad levels are brought into the system clock domain by a two-stage synchronizer and presented on a readback vector.

A reference clock is made inside the block at half the system clock rate. Pin 0 can carry that reference divided by a programmed ratio, and pin 3 can carry the reference itself. Two line-control outputs (caller-ID enable and off-hook) are steered by a mode input. With the mode input high, they follow the synchronized levels of pins 1 and 2, and those two pins are held as inputs. With the mode input low, they follow two bits of a register.

Top module: `gpio_altfn_bank`

## Requirements
- R1: While `rst` is high on a clock edge, every register clears on that edge: after it, `pad_oe`, `pad_out`, `fb_levels`, `line_cid` and `line_offhook` are all 0.
- R2: A write with `wr_sel`=0 stores `wr_data[3:0]` as the direction bits (1 = drive) and `wr_data[7:4]` as the output bits. From the next cycle on, a pin with no alternate function active has `pad_oe` equal to its direction bit and `pad_out` equal to its output bit.
- R3: `fb_levels` equals `pad_in` as sampled two clock edges earlier. It is unchanged one edge after a pad change.
- R4: With `wr_sel`=1 bit 0 set and a ratio N of 2 or more written with `wr_sel`=2 (`wr_data` is N), `pad_out[0]` is a clock that is high for exactly N and low for exactly N system cycles.
- R5: With a ratio of 0 or 1, `pad_out[0]` under its alternate function is identical to the reference clock, and so equals `pad_out[3]` when pin 3 also carries it.
- R6: With `wr_sel`=1 bit 1 set, `pad_out[3]` carries the reference clock, which changes level on every system clock edge.
- R7: While `hw_mode` is 1, `pad_oe[1]` and `pad_oe[2]` are 0 whatever their direction bits hold. When `hw_mode` returns to 0, the direction bits apply again in the next cycle.
- R8: While `hw_mode` is 1, `line_cid` equals `fb_levels[1]` and `line_offhook` equals `fb_levels[2]`. Writes to the line register have no effect on them.
- R9: While `hw_mode` is 0, `line_cid` and `line_offhook` are bits 2 and 3 of the last value written with `wr_sel`=3. The other bits of that value are ignored.
- R10: An active alternate function makes its pin drive (pin 0 for `wr_sel`=1 bit 0, pin 3 for bit 1), even with the direction bit at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | One-cycle register write strobe |
| wr_sel | input | 2 | Write target: 0 pin config, 1 alternate enables, 2 ratio, 3 line bits |
| wr_data | input | 8 | Write value |
| hw_mode | input | 1 | 1: line controls come from pins 1 and 2; 0: from the register |
| pad_in | input | 4 | Levels seen at the pads |
| pad_out | output | 4 | Values to drive on the pads |
| pad_oe | output | 4 | Pad drive enables |
| fb_levels | output | 4 | Synchronized pad levels |
| line_cid | output | 1 | Caller-ID control |
| line_offhook | output | 1 | Off-hook control |

## Verification
The two functions that collide are the register path and the mode steering of the line controls. In one cycle the bench drops `hw_mode` and writes the line register, and in another it raises `hw_mode` while a pad level is still in the synchronizer. Each expected value is queued for the cycle in which the requirements place it. The bench judges that the register value wins only once the mode is low, and that in hardware mode a pad change reaches `line_cid`/`line_offhook` no sooner than two edges later.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

    localparam int NPINS      = 4;
    localparam int DATA_W     = 8;
    localparam int DIV_W      = 8;
    localparam int PIN_DIVCLK = 0;
    localparam int PIN_CID    = 1;
    localparam int PIN_HOOK   = 2;
    localparam int PIN_REFCLK = 3;
    localparam int LINE_CID_BIT  = 2;
    localparam int LINE_HOOK_BIT = 3;

    typedef enum logic [1:0] {
        SEL_PINCFG = 2'd0,
        SEL_ALTFN  = 2'd1,
        SEL_DIVN   = 2'd2,
        SEL_LINE   = 2'd3
    } wsel_e;

    typedef struct packed {
        logic [NPINS-1:0] dir;
        logic [NPINS-1:0] dout;
        logic             alt_div;
        logic             alt_ref;
        logic [DIV_W-1:0] div_n;
        logic             line_cid;
        logic             line_hook;
    } bank_cfg_t;

    typedef struct packed {
        logic oe;
        logic out;
    } pad_drv_t;

    // Ratios below 2 collapse to 1 (reference passes through).
    function automatic logic [DIV_W-1:0] eff_div(input logic [DIV_W-1:0] n);
        return (n < DIV_W'(2)) ? DIV_W'(1) : n;
    endfunction

endpackage

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_bank_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  wsel_e             wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    output bank_cfg_t         cfg
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '0;
        end else if (wr_en) begin
            unique case (wr_sel)
                SEL_PINCFG: begin
                    cfg.dir  <= wr_data[NPINS-1:0];
                    cfg.dout <= wr_data[2*NPINS-1:NPINS];
                end
                SEL_ALTFN: begin
                    cfg.alt_div <= wr_data[0];
                    cfg.alt_ref <= wr_data[1];
                end
                SEL_DIVN: cfg.div_n <= wr_data[DIV_W-1:0];
                SEL_LINE: begin
                    cfg.line_cid  <= wr_data[LINE_CID_BIT];
                    cfg.line_hook <= wr_data[LINE_HOOK_BIT];
                end
            endcase
        end
    end

    // R1: reset clears the whole register set
    p_reset_clear_r1: assert property (@(posedge clk) rst |=> (cfg == '0));

endmodule

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stage1;

    for (genvar b = 0; b < W; b++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) begin
                stage1[b] <= 1'b0;
                q[b]      <= 1'b0;
            end else begin
                stage1[b] <= d[b];
                q[b]      <= stage1[b];
            end
        end
    end

    // R3: two edges of latency from pad to readback
    p_two_stage_lag_r3: assert property (@(posedge clk) disable iff (rst)
        $past(!rst) |=> (q == $past(d, 2)));

endmodule

// File: rtl/gpio_clkgen.sv
module gpio_clkgen
    import gpio_bank_pkg::*;
#(
    parameter int CNT_W = DIV_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] div_n,
    output logic             ref_clk,
    output logic             div_clk
);

    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt;
    logic [DIV_W-1:0] limit;
    logic             half_clk;
    logic             bypass;

    always_comb begin
        limit  = eff_div(div_n);
        bypass = (limit == DIV_W'(1));
    end

    // Divided output toggles once every "limit" system cycles.
    always_ff @(posedge clk) begin
        if (rst) begin
            ref_clk  <= 1'b0;
            half_clk <= 1'b0;
            cnt      <= '0;
        end else begin
            ref_clk <= ~ref_clk;
            if (cnt >= CNT_W'(limit) - CNT_ONE) begin
                cnt      <= '0;
                half_clk <= ~half_clk;
            end else begin
                cnt <= cnt + CNT_ONE;
            end
        end
    end

    assign div_clk = bypass ? ref_clk : half_clk;

    // R6: reference changes level on every edge out of reset
    p_ref_toggles_r6: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (ref_clk != $past(ref_clk)));

    // R4: divided phase only moves on a counter wrap
    p_div_holds_r4: assert property (@(posedge clk) disable iff (rst)
        (cnt != '0) |-> $stable(half_clk));

endmodule

// File: rtl/gpio_altfn_bank.sv
module gpio_altfn_bank
    import gpio_bank_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [1:0]  wr_sel,
    input  logic [7:0]  wr_data,
    input  logic        hw_mode,
    input  logic [3:0]  pad_in,
    output logic [3:0]  pad_out,
    output logic [3:0]  pad_oe,
    output logic [3:0]  fb_levels,
    output logic        line_cid,
    output logic        line_offhook
);

    bank_cfg_t cfg;
    logic      ref_clk;
    logic      div_clk;

    gpio_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_sel  (wsel_e'(wr_sel)),
        .wr_data (wr_data),
        .cfg     (cfg)
    );

    gpio_sync #(.W(NPINS)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pad_in),
        .q   (fb_levels)
    );

    gpio_clkgen u_clk (
        .clk     (clk),
        .rst     (rst),
        .div_n   (cfg.div_n),
        .ref_clk (ref_clk),
        .div_clk (div_clk)
    );

    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        pad_drv_t drv;
        if (i == PIN_DIVCLK) begin : g_divpin
            always_comb begin
                drv.oe  = cfg.alt_div | cfg.dir[i];
                drv.out = cfg.alt_div ? div_clk : cfg.dout[i];
            end
        end else if (i == PIN_REFCLK) begin : g_refpin
            always_comb begin
                drv.oe  = cfg.alt_ref | cfg.dir[i];
                drv.out = cfg.alt_ref ? ref_clk : cfg.dout[i];
            end
        end else if (i == PIN_CID || i == PIN_HOOK) begin : g_linepin
            always_comb begin
                drv.oe  = cfg.dir[i] & ~hw_mode;
                drv.out = cfg.dout[i];
            end
        end else begin : g_plainpin
            always_comb begin
                drv.oe  = cfg.dir[i];
                drv.out = cfg.dout[i];
            end
        end
        assign pad_oe[i]  = drv.oe;
        assign pad_out[i] = drv.out;
    end

    always_comb begin
        line_cid     = hw_mode ? fb_levels[PIN_CID]  : cfg.line_cid;
        line_offhook = hw_mode ? fb_levels[PIN_HOOK] : cfg.line_hook;
    end

    // R7: line pins never drive in hardware mode
    p_line_pins_input_r7: assert property (@(posedge clk) disable iff (rst)
        hw_mode |-> (pad_oe[PIN_HOOK:PIN_CID] == 2'b00));

    // R8: hardware mode follows synchronized pad levels
    p_line_from_pads_r8: assert property (@(posedge clk) disable iff (rst)
        hw_mode |-> (line_cid == fb_levels[PIN_CID] && line_offhook == fb_levels[PIN_HOOK]));

    // R9: a line write shows up next cycle unless in hardware mode
    p_line_from_reg_r9: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel == 2'd3) |=>
        (hw_mode || (line_cid == $past(wr_data[LINE_CID_BIT]) &&
                     line_offhook == $past(wr_data[LINE_HOOK_BIT]))));

    // R10: enabling the divided clock makes pin 0 drive
    p_alt_drives_r10: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel == 2'd1 && wr_data[0]) |=> pad_oe[PIN_DIVCLK]);

endmodule

// File: tb/sim_gpio_altfn_bank.sv
module sim_gpio_altfn_bank;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [1:0] wr_sel = 2'd0;
    logic [7:0] wr_data = 8'h00;
    logic       hw_mode = 1'b0;
    logic [3:0] pad_in = 4'b1010;
    logic [3:0] pad_out, pad_oe, fb_levels;
    logic       line_cid, line_offhook;

    always #10 clk = ~clk;

    gpio_altfn_bank u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .hw_mode(hw_mode), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
        .fb_levels(fb_levels), .line_cid(line_cid), .line_offhook(line_offhook)
    );

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_chk = 0;
    int n_err = 0;

    typedef struct {
        int          at;
        logic [13:0] mask;
        logic [13:0] val;
        string       req;
    } sb_item_t;
    sb_item_t sbq[$];

    localparam logic [13:0] M_OE   = 14'b1111_0000_0000_00;
    localparam logic [13:0] M_OUT  = 14'b0000_1111_0000_00;
    localparam logic [13:0] M_FB   = 14'b0000_0000_1111_00;
    localparam logic [13:0] M_LINE = 14'b0000_0000_0000_11;

    wire [13:0] obs = {pad_oe, pad_out, fb_levels, line_cid, line_offhook};

    function automatic logic [13:0] mk(logic [3:0] oe, logic [3:0] o, logic [3:0] fb,
                                       logic cid, logic hook);
        return {oe, o, fb, cid, hook};
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic expect_at(int dly, logic [13:0] m, logic [13:0] v, string req);
        sb_item_t it;
        it.at = cyc + dly;
        it.mask = m;
        it.val = v;
        it.req = req;
        sbq.push_back(it);
    endtask

    // Monitor: compare every queued item due in this cycle.
    always @(negedge clk) begin
        for (int k = sbq.size() - 1; k >= 0; k--) begin
            if (sbq[k].at == cyc) begin
                check((obs & sbq[k].mask) == (sbq[k].val & sbq[k].mask), sbq[k].req,
                      int'(obs & sbq[k].mask), int'(sbq[k].val & sbq[k].mask));
                sbq.delete(k);
            end
        end
    end

    task automatic step();
        @(negedge clk);
        #1;
        wr_en = 1'b0;
    endtask

    task automatic drive_wr(logic [1:0] s, logic [7:0] d);
        wr_en = 1'b1;
        wr_sel = s;
        wr_data = d;
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    endtask

    task automatic measure_div(int n);
        int hi = 0;
        int lo = 0;
        int guard = 0;
        drive_wr(2'd2, 8'(n));
        step();
        repeat (2 * n + 2) step();
        while (pad_out[0] !== 1'b1 && guard < 600) begin step(); guard++; end
        while (pad_out[0] !== 1'b0 && guard < 600) begin step(); guard++; end
        while (pad_out[0] !== 1'b1 && guard < 600) begin step(); guard++; end
        while (pad_out[0] === 1'b1 && guard < 600) begin hi++; step(); guard++; end
        while (pad_out[0] === 1'b0 && guard < 600) begin lo++; step(); guard++; end
        check(hi == n, "R4 high run", hi, n);
        check(lo == n, "R4 low run", lo, n);
    endtask

    initial begin
        repeat (600 * 1000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        step();
        // R1: reset state
        expect_at(1, M_OE | M_OUT | M_FB | M_LINE, '0, "R1 reset state");
        step();
        step();
        rst = 1'b0;
        expect_at(1, M_OE | M_OUT | M_LINE, '0, "R1 after release");
        expect_at(1, M_FB, '0, "R3 fb not yet through");
        expect_at(2, M_FB, mk(0, 0, 4'b1010, 0, 0), "R3 fb first level");
        step();
        step();

        // R2: direction and output bits
        drive_wr(2'd0, {4'b0101, 4'b1111});
        expect_at(1, M_OE | M_OUT, mk(4'b1111, 4'b0101, 0, 0, 0), "R2 all drive");
        step();
        drive_wr(2'd0, {4'b1010, 4'b0110});
        expect_at(1, M_OE | M_OUT, mk(4'b0110, 4'b1010, 0, 0, 0), "R2 mixed dir");
        step();

        // R3: synchronizer latency
        pad_in = 4'b1011;
        expect_at(1, M_FB, mk(0, 0, 4'b1010, 0, 0), "R3 one edge old");
        expect_at(2, M_FB, mk(0, 0, 4'b1011, 0, 0), "R3 two edges new");
        step();
        step();
        pad_in = 4'b0100;
        expect_at(1, M_FB, mk(0, 0, 4'b1011, 0, 0), "R3 one edge old b");
        expect_at(2, M_FB, mk(0, 0, 4'b0100, 0, 0), "R3 two edges new b");
        step();
        step();

        // R9: line bits from register, other bits ignored
        drive_wr(2'd3, 8'h04);
        expect_at(1, M_LINE, mk(0, 0, 0, 1, 0), "R9 cid bit");
        step();
        drive_wr(2'd3, 8'h08);
        expect_at(1, M_LINE, mk(0, 0, 0, 0, 1), "R9 hook bit");
        step();
        drive_wr(2'd3, 8'hF3);
        expect_at(1, M_LINE, mk(0, 0, 0, 0, 0), "R9 other bits ignored");
        step();

        // R7/R8: hardware mode
        pad_in = 4'b0110;
        drive_wr(2'd0, 8'h0F);
        step();
        step();
        step();
        hw_mode = 1'b1;
        expect_at(1, M_OE, mk(4'b1001, 0, 0, 0, 0), "R7 line pins input");
        expect_at(1, M_LINE, mk(0, 0, 0, 1, 1), "R8 from pads");
        step();
        pad_in = 4'b0010;
        drive_wr(2'd3, 8'h00);
        expect_at(1, M_LINE, mk(0, 0, 0, 1, 1), "R8 write ignored, old pads");
        expect_at(2, M_LINE, mk(0, 0, 0, 1, 0), "R8 pad change after sync");
        step();
        step();
        // same cycle: mode drops while the line register is written
        hw_mode = 1'b0;
        drive_wr(2'd3, 8'h04);
        expect_at(1, M_OE, mk(4'b1111, 0, 0, 0, 0), "R7 dir applies again");
        expect_at(1, M_LINE, mk(0, 0, 0, 1, 0), "R9 register wins after mode drop");
        step();

        // R10: alternate functions force drive
        drive_wr(2'd0, 8'h00);
        step();
        drive_wr(2'd1, 8'h01);
        expect_at(1, M_OE, mk(4'b0001, 0, 0, 0, 0), "R10 pin0 drives");
        step();
        drive_wr(2'd1, 8'h03);
        expect_at(1, M_OE, mk(4'b1001, 0, 0, 0, 0), "R10 pin3 drives");
        step();

        // R6 and R5: reference on pin 3, ratio 0 bypass on pin 0
        begin
            logic prev;
            prev = pad_out[3];
            for (int k = 0; k < 12; k++) begin
                step();
                check(pad_out[3] != prev, "R6 reference toggles", pad_out[3], !prev);
                check(pad_out[0] == pad_out[3], "R5 ratio 0 bypass", pad_out[0], pad_out[3]);
                prev = pad_out[3];
            end
        end
        drive_wr(2'd2, 8'd1);
        step();
        for (int k = 0; k < 8; k++) begin
            step();
            check(pad_out[0] == pad_out[3], "R5 ratio 1 bypass", pad_out[0], pad_out[3]);
        end

        // R4: divided clock duty and period
        measure_div(4);
        measure_div(3);
        measure_div(2);
        measure_div(6);

        step();
        step();
        if (sbq.size() != 0) begin
            n_chk++;
            n_err++;
            $display("FAIL scoreboard leftover actual=%0d expected=0", sbq.size());
        end
        summary();
        $finish;
    end

endmodule